// File: doc/BRIEF.md
# Interlocked Two-Byte Measurement Readout

This block is the register-access front end of a sensor whose 16-bit measurement has to be fetched over a byte-wide host bus in two halves. A serial-interface engine presents a byte address with a read or write strobe and write data. The converter side presents a measurement-update strobe with the new 16-bit value. The block returns one read byte per read strobe. Besides the two measurement bytes, it holds a small bank of host-writable setting bytes and a fixed identity byte. Every other address is unmapped.

A host that reads the high byte and then the low byte must never get a torn pair, where the low byte belongs to a later conversion. When the high byte is read, the low byte of that same measurement is copied into a shadow register and the pair is locked. The next low-byte read returns the shadow and releases the lock. An update that lands between the two reads, or in the same cycle as the high-byte read, changes only the live value. The host reads the high byte first.

Top module: `ilk_pair_readout`

## Requirements
- R1: After synchronous active-low reset, reads return these defaults: high measurement byte (address 0x00) = 0x19, low measurement byte (address 0x01) = 0x00, setting bytes at 0x10, 0x11, 0x12, 0x13 = 0xA5, 0x7F, 0x00, 0xC3.
- R2: Read data is registered. It appears on `bus_rdata` on the clock edge that samples `bus_rd`, and it holds its value while no read is strobed.
- R3: A read of address 0x00 returns bits 15:8 of the most recently applied measurement.
- R4: A read of 0x00 captures the low byte of the same measurement. The next read of 0x01 returns that captured byte even if updates arrived in between.
- R5: A read of 0x01 releases the capture. A further read of 0x01 with no new read of 0x00 returns the live low byte.
- R6: A read of 0x01 with no capture pending returns bits 7:0 of the most recent measurement.
- R7: When an update and a read of 0x00 fall in the same cycle, the read returns the high byte of the older measurement and captures its low byte. The new value becomes live afterwards.
- R8: A read of any unmapped address returns 0x00.
- R9: A write to an unmapped address changes no register.
- R10: A write to a setting byte (0x10 to 0x13) is returned by its next read. Writes to 0x00, 0x01 and 0x20 are ignored.
- R11: The identity byte at address 0x20 always reads 0x5A.
- R12: A read of 0x00 while a capture is already pending takes a fresh capture of the current low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| meas_upd | input | 1 | New measurement valid strobe |
| meas_value | input | 16 | New measurement value |
| bus_rdata | output | 8 | Registered read data |

## Verification
The conflict that matters is a high-byte read and a measurement update landing on the same clock edge. The bench raises both strobes in one cycle. It checks that the returned high byte and the following low-byte read both come from the value that was live before that edge. It then reads the pair again to confirm the new value did become live. Separate scenarios place updates between the two reads and repeat a high-byte read while a capture is held. These pin down the ordering of capture against update.

// File: rtl/ilk_pkg.sv
// Package: shared definitions for the interlocked measurement readout.
// Assumes: byte-wide host bus; the decode classes below cover every access.
package ilk_pkg;

    // Class of register an address selects
    typedef enum logic [2:0] {
        K_HI   = 3'd0,
        K_LO   = 3'd1,
        K_ID   = 3'd2,
        K_RW   = 3'd3,
        K_NONE = 3'd4
    } acc_kind_e;

endpackage

// File: rtl/ilk_addr_decode.sv
// Module: ilk_addr_decode
// Turns a bus address into a register class plus a one-hot hit vector for
// the setting bank. Purely combinational.
// Assumes: the fixed addresses do not overlap the setting-bank window.
module ilk_addr_decode
    import ilk_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int HI_ADDR = 'h00,
    parameter int LO_ADDR = 'h01,
    parameter int ID_ADDR = 'h20,
    parameter int RW_BASE = 'h10,
    parameter int NUM_RW  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [NUM_RW-1:0] rw_hit
);

    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);
    localparam logic [ADDR_W-1:0] ID_A = ADDR_W'(ID_ADDR);

    // One comparator per setting byte
    for (genvar i = 0; i < NUM_RW; i++) begin : g_hit
        localparam logic [ADDR_W-1:0] RW_A = ADDR_W'(RW_BASE + i);
        assign rw_hit[i] = (addr == RW_A);
    end

    // Classify the address
    always_comb begin
        if (addr == HI_A)      kind = K_HI;
        else if (addr == LO_A) kind = K_LO;
        else if (addr == ID_A) kind = K_ID;
        else if (|rw_hit)      kind = K_RW;
        else                   kind = K_NONE;
    end

endmodule

// File: rtl/ilk_meas_snapshot.sv
// Module: ilk_meas_snapshot
// Holds the live measurement, plus the shadow low byte and the lock flag
// that tie a low-byte read to the preceding high-byte read.
// Assumes: hi_rd and lo_rd are single-cycle and never both high together.
module ilk_meas_snapshot #(
    parameter int            DATA_W   = 8,
    parameter int            MEAS_W   = 2 * DATA_W,
    parameter logic [MEAS_W-1:0] MEAS_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_rd,
    input  logic              lo_rd,
    input  logic              upd,
    input  logic [MEAS_W-1:0] upd_value,
    output logic [DATA_W-1:0] live_hi,
    output logic [DATA_W-1:0] lo_view,
    output logic              locked
);

    logic [MEAS_W-1:0] meas_q;
    logic [DATA_W-1:0] shadow_q;
    logic              lock_q;

    // Live measurement register; an update replaces it whole
    always_ff @(posedge clk) begin
        if (!rst_n)   meas_q <= MEAS_RST;
        else if (upd) meas_q <= upd_value;
    end

    // Shadow capture on a high-byte read, taken from the pre-update value
    always_ff @(posedge clk) begin
        if (!rst_n)     shadow_q <= MEAS_RST[DATA_W-1:0];
        else if (hi_rd) shadow_q <= meas_q[DATA_W-1:0];
    end

    // Lock set by a high-byte read, cleared by a low-byte read
    always_ff @(posedge clk) begin
        if (!rst_n)     lock_q <= 1'b0;
        else if (hi_rd) lock_q <= 1'b1;
        else if (lo_rd) lock_q <= 1'b0;
    end

    assign live_hi = meas_q[MEAS_W-1:DATA_W];
    assign lo_view = lock_q ? shadow_q : meas_q[DATA_W-1:0];
    assign locked  = lock_q;

    // R4
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !hi_rd) |=> $stable(shadow_q));

    // R7
    snap_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_rd |=> (shadow_q == $past(meas_q[DATA_W-1:0])));

    // R5
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_rd && !hi_rd) |=> !lock_q);

endmodule

// File: rtl/ilk_rw_bank.sv
// Module: ilk_rw_bank
// Bank of host-writable setting bytes, each with its own reset default.
// Assumes: hit is one-hot or zero; zero means the write is not for the bank.
module ilk_rw_bank #(
    parameter int                   DATA_W = 8,
    parameter int                   NUM_RW = 4,
    parameter logic [NUM_RW*DATA_W-1:0] RW_RST = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [NUM_RW-1:0]        hit,
    input  logic [DATA_W-1:0]        wdata,
    output logic [NUM_RW*DATA_W-1:0] regs
);

    for (genvar i = 0; i < NUM_RW; i++) begin : g_reg
        // Setting byte i: loads its default, then takes matching writes
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i*DATA_W +: DATA_W] <= RW_RST[i*DATA_W +: DATA_W];
            else if (wr && hit[i])
                regs[i*DATA_W +: DATA_W] <= wdata;
        end

        // R10
        rw_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && hit[i]) |=> (regs[i*DATA_W +: DATA_W] == $past(wdata)));
    end

    // R9
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !(|hit)) |=> $stable(regs));

endmodule

// File: rtl/ilk_pair_readout.sv
// Module: ilk_pair_readout (top)
// Register front end: address decode, measurement snapshot, setting bank
// and a registered read-data multiplexer.
// Assumes: bus_rd is a one-cycle strobe per read; the host reads the high
// byte before the low byte when it wants a consistent pair.
module ilk_pair_readout
    import ilk_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int NUM_RW  = 4,
    parameter int HI_ADDR = 'h00,
    parameter int LO_ADDR = 'h01,
    parameter int ID_ADDR = 'h20,
    parameter int RW_BASE = 'h10,
    parameter logic [DATA_W-1:0]        ID_VALUE = 8'h5A,
    parameter logic [2*DATA_W-1:0]      MEAS_RST = 16'h1900,
    parameter logic [NUM_RW*DATA_W-1:0] RW_RST   = 32'hC3_00_7F_A5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                meas_upd,
    input  logic [2*DATA_W-1:0] meas_value,
    output logic [DATA_W-1:0]   bus_rdata
);

    localparam int MEAS_W = 2 * DATA_W;

    acc_kind_e                kind;
    logic [NUM_RW-1:0]        rw_hit;
    logic [DATA_W-1:0]        live_hi;
    logic [DATA_W-1:0]        lo_view;
    logic                     locked;
    logic [NUM_RW*DATA_W-1:0] rw_regs;
    logic [DATA_W-1:0]        rw_sel;
    logic                     hi_rd;
    logic                     lo_rd;

    ilk_addr_decode #(
        .ADDR_W (ADDR_W),
        .HI_ADDR(HI_ADDR),
        .LO_ADDR(LO_ADDR),
        .ID_ADDR(ID_ADDR),
        .RW_BASE(RW_BASE),
        .NUM_RW (NUM_RW)
    ) u_dec (
        .addr  (bus_addr),
        .kind  (kind),
        .rw_hit(rw_hit)
    );

    assign hi_rd = bus_rd && (kind == K_HI);
    assign lo_rd = bus_rd && (kind == K_LO);

    ilk_meas_snapshot #(
        .DATA_W  (DATA_W),
        .MEAS_W  (MEAS_W),
        .MEAS_RST(MEAS_RST)
    ) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_rd    (hi_rd),
        .lo_rd    (lo_rd),
        .upd      (meas_upd),
        .upd_value(meas_value),
        .live_hi  (live_hi),
        .lo_view  (lo_view),
        .locked   (locked)
    );

    ilk_rw_bank #(
        .DATA_W(DATA_W),
        .NUM_RW(NUM_RW),
        .RW_RST(RW_RST)
    ) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (bus_wr),
        .hit  (rw_hit),
        .wdata(bus_wdata),
        .regs (rw_regs)
    );

    // Pick the addressed setting byte (hit is one-hot)
    always_comb begin
        rw_sel = '0;
        for (int i = 0; i < NUM_RW; i++) begin
            if (rw_hit[i]) rw_sel = rw_sel | rw_regs[i*DATA_W +: DATA_W];
        end
    end

    // Registered read data, updated only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (kind)
                K_HI:    bus_rdata <= live_hi;
                K_LO:    bus_rdata <= lo_view;
                K_ID:    bus_rdata <= ID_VALUE;
                K_RW:    bus_rdata <= rw_sel;
                default: bus_rdata <= '0;
            endcase
        end
    end

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && kind == K_NONE) |=> (bus_rdata == '0));

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R11
    id_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && kind == K_ID) |=> (bus_rdata == ID_VALUE));

    // R12
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_rd |=> locked);

endmodule

// File: tb/sim_ilk_pair_readout.sv
// Directed bench for ilk_pair_readout: one task per scenario.
module sim_ilk_pair_readout;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       meas_upd = 1'b0;
    logic [15:0] meas_value = '0;
    logic [7:0] bus_rdata;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    ilk_pair_readout u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .meas_upd  (meas_upd),
        .meas_value(meas_value),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    // One read cycle; data is valid after the sampling edge
    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic upd(input logic [15:0] v);
        @(negedge clk);
        meas_value = v; meas_upd = 1'b1;
        @(negedge clk);
        meas_upd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 rdata after reset", bus_rdata, 8'h00);
        rd(8'h00, d); check("R1 hi default", d, 8'h19);
        rd(8'h01, d); check("R1 lo default", d, 8'h00);
        rd(8'h10, d); check("R1 rw0 default", d, 8'hA5);
        rd(8'h11, d); check("R1 rw1 default", d, 8'h7F);
        rd(8'h12, d); check("R1 rw2 default", d, 8'h00);
        rd(8'h13, d); check("R1 rw3 default", d, 8'hC3);
        rd(8'h20, d); check("R11 id value", d, 8'h5A);
    endtask

    task automatic t_hold();
        logic [7:0] d;
        rd(8'h10, d);
        repeat (3) @(negedge clk);
        check("R2 rdata holds when idle", bus_rdata, 8'hA5);
    endtask

    task automatic t_lo_only();
        logic [7:0] d;
        upd(16'hABCD);
        rd(8'h01, d); check("R6 lo without hi", d, 8'hCD);
    endtask

    task automatic t_basic();
        logic [7:0] d;
        upd(16'h1234);
        rd(8'h00, d); check("R3 hi byte", d, 8'h12);
        rd(8'h01, d); check("R4 paired lo", d, 8'h34);
    endtask

    task automatic t_tear();
        logic [7:0] d;
        upd(16'h2040);
        rd(8'h00, d); check("R3 hi before tear", d, 8'h20);
        upd(16'h3050);
        rd(8'h01, d); check("R4 lo frozen", d, 8'h40);
        rd(8'h01, d); check("R5 lo live after release", d, 8'h50);
        rd(8'h00, d); check("R3 hi after update", d, 8'h30);
        rd(8'h01, d);
    endtask

    task automatic t_same_cycle();
        logic [7:0] d;
        upd(16'h4411);
        @(negedge clk);
        bus_addr = 8'h00; bus_rd = 1'b1;
        meas_value = 16'h5522; meas_upd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; meas_upd = 1'b0;
        check("R7 hi from older value", bus_rdata, 8'h44);
        rd(8'h01, d); check("R7 lo from older value", d, 8'h11);
        rd(8'h00, d); check("R7 new hi live", d, 8'h55);
        rd(8'h01, d); check("R7 new lo live", d, 8'h22);
    endtask

    task automatic t_rehi();
        logic [7:0] d;
        upd(16'h6677);
        rd(8'h00, d); check("R12 first hi", d, 8'h66);
        upd(16'h7788);
        rd(8'h00, d); check("R12 second hi", d, 8'h77);
        rd(8'h01, d); check("R12 fresh capture", d, 8'h88);
    endtask

    task automatic t_unmapped_rd();
        logic [7:0] d;
        rd(8'h11, d);
        rd(8'h7E, d); check("R8 unmapped 0x7E", d, 8'h00);
        rd(8'h20, d);
        rd(8'hFF, d); check("R8 unmapped 0xFF", d, 8'h00);
        rd(8'h14, d); check("R8 past bank end", d, 8'h00);
    endtask

    task automatic t_unmapped_wr();
        logic [7:0] d;
        wr(8'h7E, 8'hFF);
        wr(8'h14, 8'hEE);
        wr(8'h0F, 8'hDD);
        rd(8'h10, d); check("R9 rw0 unchanged", d, 8'hA5);
        rd(8'h11, d); check("R9 rw1 unchanged", d, 8'h7F);
        rd(8'h12, d); check("R9 rw2 unchanged", d, 8'h00);
        rd(8'h13, d); check("R9 rw3 unchanged", d, 8'hC3);
        rd(8'h14, d); check("R9 0x14 still zero", d, 8'h00);
    endtask

    task automatic t_rw();
        logic [7:0] d;
        wr(8'h11, 8'h3C);
        wr(8'h13, 8'h96);
        rd(8'h11, d); check("R10 rw1 readback", d, 8'h3C);
        rd(8'h13, d); check("R10 rw3 readback", d, 8'h96);
        rd(8'h10, d); check("R10 rw0 untouched", d, 8'hA5);
        upd(16'h9A0B);
        wr(8'h00, 8'hEE);
        wr(8'h01, 8'hEE);
        wr(8'h20, 8'hEE);
        rd(8'h00, d); check("R10 hi write ignored", d, 8'h9A);
        rd(8'h01, d); check("R10 lo write ignored", d, 8'h0B);
        rd(8'h20, d); check("R11 id write ignored", d, 8'h5A);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hold();
        t_lo_only();
        t_basic();
        t_tear();
        t_same_cycle();
        t_rehi();
        t_unmapped_rd();
        t_unmapped_wr();
        t_rw();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule